// File: doc/BRIEF.md
# Row Address Clock Timer

This block paces a sequentially addressed sample memory row by row. It counts tick pulses inside each row. During the last eighth of every row it pulls an active-low row marker low, and when the row ends it releases the marker and steps the row address. After the final row it stops and raises overflow. Overflow stays set until the next start.

There are three operations. Play and record count the sample-rate tick. Record also holds the marker high for an extra load interval, given in sample ticks, before the first row starts. Cue counts a separate fast tick over a short row of eight ticks: seven with the marker high and one with it low. The mode is captured when start is pulsed. A stop pulse halts the operation and keeps the row address.

Top module: `row_clock_timer`

## Requirements
- R1: After reset the marker is high (released), row_addr is 0, overflow is 0, and ticks are ignored until a start.
- R2: In play mode (mode 2'b00), after k sample ticks counted from start, the marker is low exactly when (k mod ROW_TICKS) >= ROW_TICKS - ROW_TICKS/8, and high otherwise.
- R3: When the row with address ROWS-1 ends, overflow goes to 1, row_addr stays at ROWS-1 and the marker stays high. Further ticks change nothing until the next start.
- R4: row_addr starts at 0 and increases by one at each row end, in the same cycle that the marker returns high.
- R5: In record mode (mode 2'b01), the first LOAD_TICKS sample ticks after start keep the marker high. After them the row timing of R2 applies, counted from that point.
- R6: In cue mode (mode 2'b10), only cue_tick is counted. A row lasts CUE_TICKS ticks and the marker is low only on its last eighth (1 of 8 ticks). sample_tick is ignored.
- R7: In play and record modes cue_tick has no effect.
- R8: A stop pulse halts counting, releases the marker in the next cycle and holds row_addr and overflow. Stop wins over a start given in the same cycle.
- R9: A start clears overflow, sets row_addr to 0 and latches mode. Changes on mode at any other time have no effect. A start also restarts an operation that is running.
- R10: Mode 2'b11 behaves exactly as play.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | One-cycle pulse at the sample rate |
| cue_tick | input | 1 | One-cycle pulse at the fast cue rate |
| start | input | 1 | Begin an operation in the selected mode |
| mode | input | 2 | 00 play, 01 record, 10 cue, 11 play |
| stop | input | 1 | Halt the current operation |
| row_mark_n | output | 1 | Active-low row marker (0 = driven low, 1 = released) |
| row_addr | output | $clog2(ROWS) | Current row address |
| overflow | output | 1 | End of memory reached |

## Verification
The bench runs full operations in every mode up to and past overflow, with random tick patterns on both tick inputs. A design that counted the wrong tick source would drift from the expected marker. A design with an off-by-one low-phase boundary would show the marker falling one tick early or late. A design that failed to saturate at the last row would wrap row_addr or pull the marker low again. Directed cases cover the record load delay, which a careless design would skip or apply in play mode. They also cover stop and start in the same cycle, where the wrong priority would restart the count, and mode toggling during a run, where a design that failed to latch the mode would change its period mid-row.

// File: rtl/rct_pkg.sv
package rct_pkg;
  typedef enum logic [1:0] {
    MODE_PLAY = 2'b00,
    MODE_REC  = 2'b01,
    MODE_CUE  = 2'b10,
    MODE_ALT  = 2'b11
  } rct_mode_e;
endpackage

// File: rtl/rct_tick_sel.sv
module rct_tick_sel
  import rct_pkg::*;
#(
  parameter int ROW_TICKS = 1600,
  parameter int CUE_TICKS = 8,
  parameter int CNT_W     = $clog2(ROW_TICKS)
) (
  input  rct_mode_e        mode_q,
  input  logic             sample_tick,
  input  logic             cue_tick,
  output logic             tick,
  output logic [CNT_W-1:0] last_idx,
  output logic [CNT_W-1:0] low_from
);
  localparam int ROW_LOW = ROW_TICKS - ROW_TICKS / 8;
  localparam int CUE_LOW = CUE_TICKS - CUE_TICKS / 8;

  always_comb begin
    if (mode_q == MODE_CUE) begin
      tick     = cue_tick;
      last_idx = CNT_W'(CUE_TICKS - 1);
      low_from = CNT_W'(CUE_LOW);
    end else begin
      tick     = sample_tick;
      last_idx = CNT_W'(ROW_TICKS - 1);
      low_from = CNT_W'(ROW_LOW);
    end
  end
endmodule

// File: rtl/rct_phase_ctr.sv
module rct_phase_ctr #(
  parameter int CNT_W      = 11,
  parameter int LOAD_TICKS = 16,
  parameter int LOAD_W     = $clog2(LOAD_TICKS + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_go,
  input  logic             start_rec,
  input  logic             stop,
  input  logic             run_q,
  input  logic             run_d,
  input  logic             tick,
  input  logic [CNT_W-1:0] last_idx,
  input  logic [CNT_W-1:0] low_from,
  output logic             row_end,
  output logic             mark_n
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [LOAD_W-1:0] load_q, load_d;
  logic              mark_d;

  always_comb begin
    cnt_d   = cnt_q;
    load_d  = load_q;
    row_end = 1'b0;
    if (start_go) begin
      cnt_d  = '0;
      load_d = start_rec ? LOAD_W'(LOAD_TICKS) : '0;
    end else if (run_q && !stop && tick) begin
      if (load_q != '0) begin
        load_d = load_q - LOAD_W'(1);
      end else if (cnt_q == last_idx) begin
        cnt_d   = '0;
        row_end = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
    mark_d = !(run_d && (load_d == '0) && (cnt_d >= low_from));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      load_q <= '0;
      mark_n <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      load_q <= load_d;
      mark_n <= mark_d;
    end
  end
endmodule

// File: rtl/rct_row_ctr.sv
module rct_row_ctr #(
  parameter int ROWS   = 1200,
  parameter int ADDR_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_go,
  input  logic              row_end,
  output logic              last_row,
  output logic [ADDR_W-1:0] row_addr,
  output logic              overflow
);
  assign last_row = row_end && (row_addr == ADDR_W'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      row_addr <= '0;
      overflow <= 1'b0;
    end else if (start_go) begin
      row_addr <= '0;
      overflow <= 1'b0;
    end else if (last_row) begin
      overflow <= 1'b1;
    end else if (row_end) begin
      row_addr <= row_addr + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/row_clock_timer.sv
module row_clock_timer
  import rct_pkg::*;
#(
  parameter int ROWS       = 1200,
  parameter int ROW_TICKS  = 1600,
  parameter int CUE_TICKS  = 8,
  parameter int LOAD_TICKS = 16,
  parameter int ADDR_W     = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_tick,
  input  logic              cue_tick,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              stop,
  output logic              row_mark_n,
  output logic [ADDR_W-1:0] row_addr,
  output logic              overflow
);
  localparam int CNT_W = $clog2(ROW_TICKS);

  rct_mode_e        mode_q;
  logic             run_q, run_d;
  logic             start_go, last_row, row_end, tick;
  logic [CNT_W-1:0] last_idx, low_from;

  assign start_go = start && !stop;

  always_comb begin
    if (stop)          run_d = 1'b0;
    else if (start)    run_d = 1'b1;
    else if (last_row) run_d = 1'b0;
    else               run_d = run_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      mode_q <= MODE_PLAY;
    end else begin
      run_q <= run_d;
      if (start_go) mode_q <= rct_mode_e'(mode);
    end
  end

  rct_tick_sel #(.ROW_TICKS(ROW_TICKS), .CUE_TICKS(CUE_TICKS), .CNT_W(CNT_W)) u_sel (
    .mode_q(mode_q), .sample_tick(sample_tick), .cue_tick(cue_tick),
    .tick(tick), .last_idx(last_idx), .low_from(low_from)
  );

  rct_phase_ctr #(.CNT_W(CNT_W), .LOAD_TICKS(LOAD_TICKS)) u_phase (
    .clk(clk), .rst(rst), .start_go(start_go),
    .start_rec(mode == MODE_REC), .stop(stop),
    .run_q(run_q), .run_d(run_d), .tick(tick),
    .last_idx(last_idx), .low_from(low_from),
    .row_end(row_end), .mark_n(row_mark_n)
  );

  rct_row_ctr #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_rows (
    .clk(clk), .rst(rst), .start_go(start_go), .row_end(row_end),
    .last_row(last_row), .row_addr(row_addr), .overflow(overflow)
  );
endmodule

// File: rtl/rct_checker.sv
module rct_checker #(
  parameter int ROWS   = 1200,
  parameter int ADDR_W = $clog2(ROWS)
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              stop,
  input logic              row_mark_n,
  input logic [ADDR_W-1:0] row_addr,
  input logic              overflow
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (row_mark_n && row_addr == '0 && !overflow));

  p_stop_release_r8: assert property (@(posedge clk) disable iff (rst)
    stop |=> (row_mark_n && $stable(row_addr) && $stable(overflow)));

  p_row_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(start) && row_addr != $past(row_addr))
      |-> (row_addr == $past(row_addr) + ADDR_W'(1)));

  p_rise_step_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(row_mark_n) && !$past(stop) && !$past(start))
      |-> (row_addr == $past(row_addr) + ADDR_W'(1) || overflow));

  p_overflow_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (overflow && !start) |=> (overflow && $stable(row_addr)));

  p_overflow_mark_r3: assert property (@(posedge clk) disable iff (rst)
    overflow |-> row_mark_n);

  p_row_bound_r4: assert property (@(posedge clk) disable iff (rst)
    row_addr < ADDR_W'(ROWS));
endmodule

bind row_clock_timer rct_checker #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .stop(stop),
  .row_mark_n(row_mark_n), .row_addr(row_addr), .overflow(overflow)
);

// File: tb/row_clock_timer_test.sv
module row_clock_timer_test;
  localparam int ROWS   = 5;
  localparam int RT     = 16;
  localparam int CT     = 8;
  localparam int LT     = 4;
  localparam int ADDR_W = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_tick = 1'b0, cue_tick = 1'b0, start = 1'b0, stop = 1'b0;
  logic [1:0] mode = 2'b00;
  logic row_mark_n, overflow;
  logic [ADDR_W-1:0] row_addr;

  int checks = 0, failures = 0;
  int ref_mode = 0, k = 0;
  bit stopped = 1'b1, done = 1'b0;

  always #10 clk = ~clk;

  row_clock_timer #(.ROWS(ROWS), .ROW_TICKS(RT), .CUE_TICKS(CT), .LOAD_TICKS(LT)) uut (
    .clk(clk), .rst(rst), .sample_tick(sample_tick), .cue_tick(cue_tick),
    .start(start), .mode(mode), .stop(stop),
    .row_mark_n(row_mark_n), .row_addr(row_addr), .overflow(overflow)
  );

  // expected {mark, row, overflow} after k counted ticks in mode md
  function automatic logic [ADDR_W+1:0] model(input int md, input int kk);
    int p, eff, row, pos;
    p   = (md == 2) ? CT : RT;
    eff = (md == 1) ? kk - LT : kk;
    if (eff < 0) return {1'b1, ADDR_W'(0), 1'b0};
    row = eff / p;
    pos = eff % p;
    if (row >= ROWS) return {1'b1, ADDR_W'(ROWS - 1), 1'b1};
    return {(pos < p - p / 8), ADDR_W'(row), 1'b0};
  endfunction

  function automatic string tag_of(input int md);
    case (md)
      1:       return "R5 R4 R7 R9";
      2:       return "R6 R4 R9";
      3:       return "R10 R4 R7";
      default: return "R2 R4 R7 R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [ADDR_W+1:0] exp);
    logic [ADDR_W+1:0] act;
    act = {row_mark_n, row_addr, overflow};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {mark,row,ovf} actual=%b expected=%b (k=%0d)", tag, act, exp, k);
    end
  endtask

  function automatic logic [ADDR_W+1:0] expected();
    logic [ADDR_W+1:0] e;
    e = model(ref_mode, k);
    if (stopped) e[ADDR_W+1] = 1'b1;
    return e;
  endfunction

  task automatic do_start(input int md, input bit with_stop);
    @(negedge clk);
    start = 1'b1; stop = with_stop; mode = 2'(md);
    sample_tick = 1'b0; cue_tick = 1'b0;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    if (with_stop) stopped = 1'b1;
    else begin ref_mode = md; k = 0; stopped = 1'b0; end
    check(with_stop ? "R8" : "R9", expected());
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      sample_tick = 1'($urandom % 2);
      cue_tick    = 1'($urandom % 2);
      mode        = 2'($urandom % 4);
      if (!stopped && ((ref_mode == 2) ? cue_tick : sample_tick)) k++;
      @(negedge clk);
      if (model(ref_mode, k) & 1) check("R3", expected());
      else if (stopped) check("R8", expected());
      else check(tag_of(ref_mode), expected());
    end
    sample_tick = 1'b0; cue_tick = 1'b0;
  endtask

  task automatic do_stop();
    stop = 1'b1; sample_tick = 1'b1; cue_tick = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    stopped = 1'b1;
    check("R8", expected());
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    stopped = 1'b1; ref_mode = 0; k = 0;
    check("R1", {1'b1, ADDR_W'(0), 1'b0});
    sample_tick = 1'b1; cue_tick = 1'b1;
    @(negedge clk);
    check("R1", {1'b1, ADDR_W'(0), 1'b0});
    sample_tick = 1'b0; cue_tick = 1'b0;

    do_start(0, 1'b0); run(260);           // play to overflow, then hold
    do_start(1, 1'b0); run(260);           // record with load delay
    do_start(2, 1'b0); run(150);           // cue rows
    do_start(3, 1'b0); run(260);           // alternate play encoding
    do_start(0, 1'b0); run(40);            // stop mid-run
    do_stop(); run(40);
    do_start(2, 1'b0); run(20);            // stop wins over start
    do_start(0, 1'b1); run(30);
    do_start(1, 1'b0); run(30);            // restart while running
    do_start(0, 1'b0); run(60);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule